// File: doc/BRIEF.md
# Front Panel Key Encoder with Settle Delay

The block turns a bank of active-low front-panel key lines into a compact key code that a processor can read. Key lines are organised in groups of eight. Line number `n` is encoded as `{group, digit}`, where `digit = n mod 8` and `group = n / 8`. When several lines are low together, the lowest-numbered line wins.

Any low line drives the active-low key-present output at once, after input synchronisation. The press must then stay continuously present for a settling window of `SETTLE_US` microseconds, derived from `CLK_HZ`. At the end of that window the block loads the encoded value into a held key register and raises an interrupt. The processor acknowledges the interrupt with a one-cycle read strobe. No further capture can take place until every key has been released.

Top module: `fpk_key_encoder`

## Requirements
- R1: After reset, `key_code` is 0, `key_irq` is 0 and `any_key_n` is 1.
- R2: `any_key_n` goes low exactly `SYNC_STAGES` clock edges after any `key_n` line is sampled low, and returns high the same number of edges after all lines are sampled high.
- R3: The captured code for line `n` is `n` in binary. The low 3 bits are the digit within the group of eight, and the upper `GRP_W` bits are the group number. For example, line 10 (octal 12) gives digit 010 and group 1.
- R4: When several lines are low at once, the code is that of the lowest-numbered low line.
- R5: A capture happens on the edge where the synchronised key-present condition has been seen on `DELAY_CYC` consecutive edges, with `DELAY_CYC = (CLK_HZ/1e6)*SETTLE_US`. `key_irq` rises on that same edge.
- R6: If all keys are released before the window completes, the count restarts from zero. No capture occurs and `key_code` is unchanged.
- R7: `key_irq` stays high until `rd_ack` is sampled high, and it is low from the following edge.
- R8: After a capture, no further capture happens while any key remains held, whatever `rd_ack` does.
- R9: `key_code` holds its last captured value between presses, across acknowledgements and across aborted presses.
- R10: If a capture and `rd_ack` fall on the same edge, the capture wins and `key_irq` is high after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| key_n | input | NUM_GROUPS*8 | Key lines, active low, asynchronous |
| rd_ack | input | 1 | Processor read strobe; clears the interrupt |
| any_key_n | output | 1 | Low while any synchronised key line is low |
| key_code | output | GRP_W+3 | Held code of the last captured key |
| key_irq | output | 1 | Interrupt: a new code has been captured |

## Verification
If the settle counter fails to restart on a release, or counts one cycle too many or too few, the interrupt edge moves or appears for an aborted press. The per-edge reference model sees this on the very cycle of the wrong edge. A wrong priority or group field shows up in `key_code` on the first cycle after the capture edge. A hold state that does not block re-capture raises a second interrupt while the key is still down. This becomes visible `DELAY_CYC` cycles after an acknowledge.

// File: rtl/fpk_pkg.sv
// Shared constants, types and helper functions for the key encoder.
package fpk_pkg;

    localparam int LINES_PER_GROUP = 8;
    localparam int DIGIT_W         = 3;

    // Settle controller states: hunting for a stable press, or holding after capture.
    typedef enum logic {
        ST_HUNT = 1'b0,
        ST_HOLD = 1'b1
    } settle_st_t;

    // Returns the index of the lowest set bit of an eight-line group (0 if none).
    function automatic logic [DIGIT_W-1:0] low_digit(input logic [LINES_PER_GROUP-1:0] v);
        logic [DIGIT_W-1:0] d;
        d = '0;
        for (int i = LINES_PER_GROUP - 1; i >= 0; i--) begin
            if (v[i]) d = DIGIT_W'(i);
        end
        return d;
    endfunction

endpackage

// File: rtl/fpk_sync.sv
// Multi-stage synchroniser for asynchronous active-low key lines.
// Assumes: each line is a slow, level-type signal; reset value is "released" (all ones).
module fpk_sync #(
    parameter int WIDTH  = 16,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] raw_n,
    output logic [WIDTH-1:0] sync_n
);

    logic [STAGES-1:0][WIDTH-1:0] chain_q;

    // Shift the raw lines through the synchroniser chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= '1;
        end else begin
            chain_q[0] <= raw_n;
            for (int s = 1; s < STAGES; s++) begin
                chain_q[s] <= chain_q[s-1];
            end
        end
    end

    assign sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/fpk_prio_enc.sv
// Two-level priority encoder: lowest set line within each group of eight,
// then lowest group that has any set line.
// Assumes: hit is active high and already synchronised.
module fpk_prio_enc
    import fpk_pkg::*;
#(
    parameter int NUM_GROUPS = 2,
    parameter int GRP_W      = 1,
    parameter int NUM_KEYS   = NUM_GROUPS * LINES_PER_GROUP,
    parameter int CODE_W     = GRP_W + DIGIT_W
) (
    input  logic [NUM_KEYS-1:0] hit,
    output logic [CODE_W-1:0]   code,
    output logic                any
);

    logic [NUM_GROUPS-1:0][DIGIT_W-1:0] grp_digit;
    logic [NUM_GROUPS-1:0]              grp_vld;
    logic [GRP_W-1:0]                   sel_grp;
    logic [DIGIT_W-1:0]                 sel_dig;

    genvar g;
    generate
        for (g = 0; g < NUM_GROUPS; g++) begin : g_group
            assign grp_vld[g]   = |hit[g*LINES_PER_GROUP +: LINES_PER_GROUP];
            assign grp_digit[g] = low_digit(hit[g*LINES_PER_GROUP +: LINES_PER_GROUP]);
        end
    endgenerate

    // Pick the lowest-numbered group holding a pressed line.
    always_comb begin
        sel_grp = '0;
        sel_dig = '0;
        for (int i = NUM_GROUPS - 1; i >= 0; i--) begin
            if (grp_vld[i]) begin
                sel_grp = GRP_W'(i);
                sel_dig = grp_digit[i];
            end
        end
    end

    assign code = {sel_grp, sel_dig};
    assign any  = |grp_vld;

endmodule

// File: rtl/fpk_settle_timer.sv
// Settle controller: counts consecutive cycles with a key present and fires a
// single capture strobe when the window completes.
// Assumes: any is synchronous. It re-arms only after every key is released.
module fpk_settle_timer
    import fpk_pkg::*;
#(
    parameter int DELAY_CYC = 300000,
    parameter int CNT_W     = (DELAY_CYC > 1) ? $clog2(DELAY_CYC) : 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic any,
    output logic latch_stb
);

    localparam logic [CNT_W-1:0] LAST = CNT_W'(DELAY_CYC - 1);

    settle_st_t       state_q;
    logic [CNT_W-1:0] cnt_q;

    // Advance the settle count and move between hunting and holding.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_HUNT;
            cnt_q   <= '0;
        end else begin
            case (state_q)
                ST_HUNT: begin
                    if (!any) begin
                        cnt_q <= '0;
                    end else if (cnt_q == LAST) begin
                        cnt_q   <= '0;
                        state_q <= ST_HOLD;
                    end else begin
                        cnt_q <= cnt_q + CNT_W'(1);
                    end
                end
                ST_HOLD: begin
                    if (!any) state_q <= ST_HUNT;
                end
                default: state_q <= ST_HUNT;
            endcase
        end
    end

    assign latch_stb = (state_q == ST_HUNT) && any && (cnt_q == LAST);

endmodule

// File: rtl/fpk_code_latch.sv
// Holds the captured key code and the interrupt flag seen by the processor.
// Assumes: a capture strobe takes precedence over an acknowledge on the same edge.
module fpk_code_latch #(
    parameter int CODE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              latch_stb,
    input  logic [CODE_W-1:0] enc_code,
    input  logic              rd_ack,
    output logic [CODE_W-1:0] key_code,
    output logic              key_irq
);

    // Load the code on capture; otherwise hold it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            key_code <= '0;
        end else if (latch_stb) begin
            key_code <= enc_code;
        end
    end

    // Set the interrupt on capture, clear it on acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            key_irq <= 1'b0;
        end else if (latch_stb) begin
            key_irq <= 1'b1;
        end else if (rd_ack) begin
            key_irq <= 1'b0;
        end
    end

endmodule

// File: rtl/fpk_key_encoder.sv
// Front-panel key encoder top: synchronises key lines, priority-encodes them,
// waits a settling window and captures the code with an interrupt.
// Assumes: the clock frequency is an integer number of MHz.
module fpk_key_encoder
    import fpk_pkg::*;
#(
    parameter int NUM_GROUPS  = 2,
    parameter int SYNC_STAGES = 2,
    parameter int CLK_HZ      = 50_000_000,
    parameter int SETTLE_US   = 6000,
    parameter int NUM_KEYS    = NUM_GROUPS * LINES_PER_GROUP,
    parameter int GRP_W       = (NUM_GROUPS > 1) ? $clog2(NUM_GROUPS) : 1,
    parameter int CODE_W      = GRP_W + DIGIT_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_KEYS-1:0] key_n,
    input  logic                rd_ack,
    output logic                any_key_n,
    output logic [CODE_W-1:0]   key_code,
    output logic                key_irq
);

    localparam int DELAY_RAW = (CLK_HZ / 1_000_000) * SETTLE_US;
    localparam int DELAY_CYC = (DELAY_RAW < 1) ? 1 : DELAY_RAW;

    logic [NUM_KEYS-1:0] sync_n;
    logic [CODE_W-1:0]   enc_code;
    logic                enc_any;
    logic                latch_stb;

    fpk_sync #(
        .WIDTH  (NUM_KEYS),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw_n  (key_n),
        .sync_n (sync_n)
    );

    fpk_prio_enc #(
        .NUM_GROUPS (NUM_GROUPS),
        .GRP_W      (GRP_W),
        .NUM_KEYS   (NUM_KEYS),
        .CODE_W     (CODE_W)
    ) u_enc (
        .hit  (~sync_n),
        .code (enc_code),
        .any  (enc_any)
    );

    fpk_settle_timer #(
        .DELAY_CYC (DELAY_CYC)
    ) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .any       (enc_any),
        .latch_stb (latch_stb)
    );

    fpk_code_latch #(
        .CODE_W (CODE_W)
    ) u_latch (
        .clk       (clk),
        .rst_n     (rst_n),
        .latch_stb (latch_stb),
        .enc_code  (enc_code),
        .rd_ack    (rd_ack),
        .key_code  (key_code),
        .key_irq   (key_irq)
    );

    assign any_key_n = ~enc_any;

endmodule

// File: rtl/fpk_key_encoder_chk.sv
// Property checker for the key encoder, bound to the top module.
module fpk_key_encoder_chk #(
    parameter int CODE_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rd_ack,
    input logic              any_key_n,
    input logic [CODE_W-1:0] key_code,
    input logic              key_irq,
    input logic              latch_stb
);

    // R7: without an acknowledge the interrupt stays up.
    p_irq_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        key_irq && !rd_ack |=> key_irq);

    // R7: an acknowledge without a capture clears the interrupt.
    p_ack_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rd_ack && !latch_stb |=> !key_irq);

    // R10: a capture sets the interrupt even when acknowledged on the same edge.
    p_capture_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
        latch_stb |=> key_irq);

    // R9: the code changes only through a capture.
    p_code_held_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !latch_stb |=> $stable(key_code));

    // R5: an interrupt rises only while a key was present.
    p_rise_needs_key_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(key_irq) |-> $past(any_key_n) == 1'b0);

    // R8: captures never fire on back-to-back edges.
    p_single_capture_r8: assert property (@(posedge clk) disable iff (!rst_n)
        latch_stb |=> !latch_stb);

    // R5: a capture only happens with a key present.
    p_capture_key_r5: assert property (@(posedge clk) disable iff (!rst_n)
        latch_stb |-> !any_key_n);

endmodule

bind fpk_key_encoder fpk_key_encoder_chk #(
    .CODE_W (CODE_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_ack    (rd_ack),
    .any_key_n (any_key_n),
    .key_code  (key_code),
    .key_irq   (key_irq),
    .latch_stb (latch_stb)
);

// File: tb/fpk_key_encoder_tb.sv
module fpk_key_encoder_tb;

    localparam int NUM_GROUPS  = 2;
    localparam int SYNC_STAGES = 2;
    localparam int CLK_HZ      = 50_000_000;
    localparam int SETTLE_US   = 2;
    localparam int NK          = NUM_GROUPS * 8;
    localparam int GRP_W       = (NUM_GROUPS > 1) ? $clog2(NUM_GROUPS) : 1;
    localparam int CODE_W      = GRP_W + 3;
    localparam int DELAY       = (CLK_HZ / 1_000_000) * SETTLE_US;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NK-1:0]     key_n = '1;
    logic              rd_ack = 1'b0;
    logic              any_key_n;
    logic [CODE_W-1:0] key_code;
    logic              key_irq;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    fpk_key_encoder #(
        .NUM_GROUPS  (NUM_GROUPS),
        .SYNC_STAGES (SYNC_STAGES),
        .CLK_HZ      (CLK_HZ),
        .SETTLE_US   (SETTLE_US)
    ) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .key_n     (key_n),
        .rd_ack    (rd_ack),
        .any_key_n (any_key_n),
        .key_code  (key_code),
        .key_irq   (key_irq)
    );

    // Behavioural reference model, evaluated on every rising edge.
    logic [NK-1:0] m_sy [SYNC_STAGES];
    int            m_run  = 0;
    bit            m_hold = 1'b0;
    bit            m_irq  = 1'b0;
    int            m_code = 0;
    bit            m_ok   = 1'b0;

    always @(posedge clk) begin
        logic [NK-1:0] pressed;
        int            low;
        bit            nirq;
        if (!rst_n) begin
            for (int s = 0; s < SYNC_STAGES; s++) m_sy[s] = '1;
            m_run = 0; m_hold = 0; m_irq = 0; m_code = 0; m_ok = 1;
        end else if (m_ok) begin
            pressed = ~m_sy[SYNC_STAGES-1];
            nirq = m_irq;
            if (rd_ack) nirq = 0;
            if (m_hold) begin
                if (pressed == '0) m_hold = 0;
            end else if (pressed != '0) begin
                m_run = m_run + 1;
                if (m_run == DELAY) begin
                    low = 0;
                    for (int i = NK - 1; i >= 0; i--) if (pressed[i]) low = i;
                    m_code = low;
                    nirq   = 1;
                    m_hold = 1;
                    m_run  = 0;
                end
            end else begin
                m_run = 0;
            end
            m_irq = nirq;
            for (int s = SYNC_STAGES - 1; s > 0; s--) m_sy[s] = m_sy[s-1];
            m_sy[0] = key_n;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // Per-cycle comparison against the model on the falling edge.
    always @(negedge clk) begin
        if (m_ok && !done) begin
            check("R2 any_key_n", int'(any_key_n), int'(m_sy[SYNC_STAGES-1] == '1));
            check("R7 key_irq", int'(key_irq), int'(m_irq));
            check("R3 key_code", int'(key_code), m_code);
        end
    end

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 20);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        bit seen;
        cyc(5);
        rst_n = 1'b1;
        cyc(1);
        check("R1 code", int'(key_code), 0);
        check("R1 irq", int'(key_irq), 0);
        check("R1 any", int'(any_key_n), 1);

        // Line 10 (octal 12): group 1, digit 2.
        key_n[10] = 1'b0;
        cyc(SYNC_STAGES);
        check("R2 any low", int'(any_key_n), 0);
        cyc(DELAY - 3);
        check("R5 irq early", int'(key_irq), 0);
        cyc(3);
        check("R5 irq set", int'(key_irq), 1);
        check("R3 code 012", int'(key_code), 10);
        cyc(10);
        check("R7 irq held", int'(key_irq), 1);
        rd_ack = 1'b1; cyc(1); rd_ack = 1'b0; cyc(1);
        check("R7 irq cleared", int'(key_irq), 0);
        cyc(2 * DELAY);
        check("R8 no recapture", int'(key_irq), 0);
        key_n = '1;
        cyc(SYNC_STAGES + 2);
        check("R2 any high", int'(any_key_n), 1);
        check("R9 code held", int'(key_code), 10);

        // Two keys: line 15 and line 3.
        key_n[15] = 1'b0; key_n[3] = 1'b0;
        cyc(DELAY + 10);
        check("R4 code 3", int'(key_code), 3);
        rd_ack = 1'b1; cyc(1); rd_ack = 1'b0;
        key_n = '1; cyc(6);

        // Lines 9 and 14, both in group 1.
        key_n[14] = 1'b0; key_n[9] = 1'b0;
        cyc(DELAY + 10);
        check("R4 code 9", int'(key_code), 9);
        rd_ack = 1'b1; cyc(1); rd_ack = 1'b0;
        key_n = '1; cyc(6);

        // Aborted presses restart the window.
        key_n[5] = 1'b0; cyc(DELAY / 2 + 20);
        key_n = '1; cyc(4);
        key_n[5] = 1'b0; cyc(DELAY / 2 + 20);
        key_n = '1; cyc(6);
        check("R6 no capture", int'(key_irq), 0);
        check("R9 code unchanged", int'(key_code), 9);

        // Capture with acknowledge held high.
        rd_ack = 1'b1;
        key_n[7] = 1'b0;
        seen = 1'b0;
        for (int i = 0; i < DELAY + 10; i++) begin
            cyc(1);
            if (key_irq) seen = 1'b1;
        end
        check("R10 irq pulse", int'(seen), 1);
        check("R10 code 7", int'(key_code), 7);
        check("R7 irq cleared by ack", int'(key_irq), 0);
        rd_ack = 1'b0;
        key_n = '1; cyc(6);

        // Reset during a held capture.
        key_n[2] = 1'b0;
        cyc(DELAY + 6);
        check("R5 irq before reset", int'(key_irq), 1);
        rst_n = 1'b0; cyc(2);
        check("R1 code after reset", int'(key_code), 0);
        check("R1 irq after reset", int'(key_irq), 0);
        key_n = '1;
        rst_n = 1'b1;
        cyc(5);
        finish_run();
    end

endmodule